// File: doc/BRIEF.md
# Transmit LED Gate with Stuck-On Cutoff

This block sits between the asynchronous transmit data pin of an infrared transceiver and the enable of its LED driver. A high level on the pin lights the LED. A rising edge arms the drive path, and a cycle counter removes the drive if the pin stays high longer than a set time. After such a cutoff the LED stays dark until the pin goes low and then rises again. This protects the emitter from a stuck transmit line.

Several control inputs gate the drive. These are a transmit-enable bit, a sleep bit, and a busy flag that is high while a serial control exchange uses the shared data pin. Any one of these blanks the LED at once. It also drops the armed state, so the LED needs a fresh edge once the gate reopens. A mode bit selects the low-current (SIR) or high-current (MIR) drive level. An active-low echo output mirrors the emitted pulses onto the receive side.

The pin passes through two synchroniser flops and one edge-history flop. The LED therefore follows the pin three clock cycles late, on both edges. The cutoff time is `TIMEOUT_CYCLES` clock cycles of lit LED. Its default is 14 µs at `TICKS_PER_US`.

Top module: `tx_led_gate`

## Requirements
- R1: With all gates open, a high pulse on `tx_pin` of N cycles, where N is at most `TIMEOUT_CYCLES`, gives exactly N cycles of `led_on`, delayed 3 clock cycles behind the pin.
- R2: If `tx_pin` stays high, `led_on` is high for exactly `TIMEOUT_CYCLES` consecutive cycles and then goes low while the pin is still high.
- R3: After a cutoff, `led_on` stays low until `tx_pin` has been low for at least one sampled cycle and has risen again.
- R4: While `sleep` is 1, `led_on` is 0, whatever `tx_pin` does.
- R5: While `ctl_busy` is 1, `led_on` is 0, so serial data toggling `tx_pin` never pulses the LED.
- R6: While `tx_enable` is 0, `led_on` is 0.
- R7: Any gate (`sleep`=1, `ctl_busy`=1 or `tx_enable`=0) that is active at a clock edge clears the armed state. If the gate then opens while `tx_pin` is still high, `led_on` stays 0 until a new rising edge.
- R8: `led_high_drive` is 1 exactly when `led_on` is 1 and `mir_mode` is 1 (MIR). With `mir_mode`=0 (SIR) it stays 0.
- R9: `rx_echo_n` is the inverse of `led_on`: it is low while the LED is lit and high otherwise.
- R10: During reset and after it, `led_on`=0 and `rx_echo_n`=1. A `tx_pin` that is already high when reset is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pin | input | 1 | Asynchronous transmit data pin, high = light |
| tx_enable | input | 1 | Transmit enable control bit, 0 blanks the LED |
| sleep | input | 1 | Shutdown control bit, 1 blanks the LED |
| ctl_busy | input | 1 | High while a serial control exchange is pending or active |
| mir_mode | input | 1 | 1 selects high (MIR) drive current, 0 low (SIR) |
| led_on | output | 1 | LED drive enable |
| led_high_drive | output | 1 | High-current drive qualifier while lit |
| rx_echo_n | output | 1 | Active-low echo of emitted pulses |

## Verification
The hardest case is a gate that closes in the middle of a held-high pulse and opens again before the pin falls. Here the LED must stay dark even though the pin is high and every gate is open. The stimulus holds the pin high, raises `ctl_busy` (or `sleep`) for a few cycles partway into the pulse, and keeps the pin high well after the gate drops before it finally pulses the pin again. The cutoff boundary is reached with a short timeout parameter, so that held pulses run past the exact cycle count and back-to-back edges follow right after a cutoff.

// File: rtl/tx_led_gate.sv
module tx_led_gate #(
  parameter int TICKS_PER_US   = 100,
  parameter int TIMEOUT_CYCLES = 14 * TICKS_PER_US,
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_pin,
  input  logic tx_enable,
  input  logic sleep,
  input  logic ctl_busy,
  input  logic mir_mode,
  output logic led_on,
  output logic led_high_drive,
  output logic rx_echo_n
);

  logic          meta_q, sync_q, hist_q;
  logic          armed_q;
  logic [CW-1:0] lit_cnt_q;
  logic          blocked, rise, expire;

  assign blocked = !tx_enable || sleep || ctl_busy;
  assign rise    = sync_q && !hist_q;
  assign expire  = (lit_cnt_q == CW'(TIMEOUT_CYCLES - 1));

  // sync flops reset high: a pin already high at reset release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= tx_pin;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      lit_cnt_q <= '0;
    end else if (!sync_q || blocked) begin
      armed_q   <= 1'b0;
      lit_cnt_q <= '0;
    end else if (rise) begin
      armed_q   <= 1'b1;
      lit_cnt_q <= '0;
    end else if (armed_q) begin
      if (expire) armed_q <= 1'b0;
      lit_cnt_q <= lit_cnt_q + 1'b1;
    end
  end

  assign led_on         = armed_q && !blocked;
  assign led_high_drive = led_on && mir_mode;
  assign rx_echo_n      = !led_on;

  int unsigned on_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_run_q <= 0;
    else        on_run_q <= led_on ? on_run_q + 1 : 0;
  end

  AST_RELEASE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |=> !led_on); // R1
  AST_MAX_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    led_on |-> on_run_q < TIMEOUT_CYCLES); // R2
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_on) |-> $past(sync_q && !hist_q)); // R3
  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !led_on); // R4
  AST_GATE_REOPEN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_busy) |-> !led_on); // R7

endmodule

// File: tb/tx_led_gate_test.sv
`timescale 1ns/1ps
module tx_led_gate_test;
  localparam int TO = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, en = 1'b0, slp = 1'b0, busy = 1'b0, mir = 1'b0;
  logic led, hi, echo_n;

  tx_led_gate #(.TICKS_PER_US(2)) uut (
    .clk(clk), .rst_n(rst_n), .tx_pin(pin), .tx_enable(en), .sleep(slp),
    .ctl_busy(busy), .mir_mode(mir), .led_on(led), .led_high_drive(hi),
    .rx_echo_n(echo_n));

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;
  string tag = "R10";

  // reference model: pin history and edges since last delayed rise
  bit h0 = 1, h1 = 1, h2 = 1;
  int since = -1;

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = 1; h1 = 1; h2 = 1; since = -1;
    end else begin
      if (!h1 || !en || slp || busy) since = -1;
      else if (!h2) since = 0;
      else if (since >= 0) since = since + 1;
      h2 = h1; h1 = h0; h0 = pin;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit exp_led;
      exp_led = rst_n && since >= 0 && since < TO && en && !slp && !busy;
      vectors++;
      if (led !== exp_led) begin
        errors++;
        $display("FAIL %s led_on=%b expected %b at t=%0t", tag, led, exp_led, $time);
      end
      if (hi !== (exp_led && mir)) begin
        errors++;
        $display("FAIL R8 led_high_drive=%b expected %b at t=%0t", hi, exp_led && mir, $time);
      end
      if (echo_n !== !exp_led) begin
        errors++;
        $display("FAIL R9 rx_echo_n=%b expected %b at t=%0t", echo_n, !exp_led, $time);
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse(input int w, input int gap);
    pin = 1; hold(w); pin = 0; hold(gap);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tag = "R10"; hold(4); rst_n = 1; en = 1; hold(12);
    tag = "R1"; pin = 0; hold(4);
    pulse(1, 5); pulse(3, 4); pulse(10, 6); pulse(TO, 6); pulse(2, 1);
    hold(6);
    tag = "R2"; pin = 1; hold(TO + 20);
    tag = "R3"; hold(10); pin = 0; hold(1); pin = 1; hold(TO + 8);
    pin = 0; hold(4); pin = 1; hold(5); pin = 0; hold(6);
    tag = "R8"; mir = 1; pulse(7, 4); pulse(TO + 5, 5); mir = 0; pulse(4, 4);
    tag = "R4"; slp = 1; for (int i = 0; i < 6; i++) pulse(i + 1, 2);
    pin = 1; hold(5); slp = 0; hold(8); pin = 0; hold(4); pulse(5, 5);
    tag = "R5"; busy = 1;
    for (int i = 0; i < 24; i++) begin pin = i[0] ^ i[2]; hold(1); end
    pin = 0; busy = 0; hold(5); pulse(3, 5);
    tag = "R6"; en = 0; pulse(6, 3); pulse(TO + 2, 3); en = 1; pulse(4, 5);
    tag = "R7"; pin = 1; hold(8); busy = 1; hold(3); busy = 0; hold(12);
    pin = 0; hold(3); pin = 1; hold(6); slp = 1; hold(1); slp = 0; hold(6);
    pin = 0; hold(3); pin = 1; hold(4); en = 0; hold(2); en = 1; hold(5);
    pin = 0; hold(5);
    tag = "R1";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45) pin = ~pin;
      busy = (r > 95);
      slp = (r == 50);
      mir = (r < 30);
      hold(1);
    end
    busy = 0; slp = 0; pin = 0; hold(6);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule